// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block gathers the interrupt requests of a small microcontroller: two timer overflow pulses, a serial receive pulse and a serial transmit pulse, and two active-low external pins. It keeps the pending flags in software-visible register images. It picks the most urgent enabled request and offers the CPU core a fixed service address. When the core acknowledges that address, the block marks a service routine in progress and clears the flag the hardware owns.

Each external pin has its own mode bit. In edge mode a high-then-low pair of samples latches a flag that stays set until vectoring or a software write. In level mode the flag simply follows the sampled low level. The serial receive and transmit flags are merged into a single request. Hardware never clears them. Software clears them through their own register.

Top module: `irq5_ctrl`

## Requirements
- R1: After reset the control image, the enable image and the serial image read 0, `vec_valid` is 0 and `in_service` is 0.
- R2: With control bit 0 (pin 0) or bit 2 (pin 1) at 1, a pin sampled 1 and then 0 sets control bit 1 (pin 0) or bit 3 (pin 1). The bit is visible at the second rising clock edge after the pin falls. A pin that then stays low does not set the bit again once it has been cleared.
- R3: With the mode bit at 0, control bit 1 or 3 equals the inverse of the pin sampled at the previous edge. Software writes to it have no effect.
- R4: A one-cycle `t0_ovf` pulse sets control bit 5, and a one-cycle `t1_ovf` pulse sets control bit 7.
- R5: `rx_done` sets serial bit 0 and `tx_done` sets serial bit 1. Their OR is the serial request, and vectoring to it leaves both bits unchanged.
- R6: Enable bit 7 is the global enable. Enable bits 0 to 4 gate pin 0, timer 0, pin 1, timer 1 and serial, in that order. A request is offered only when both its own enable bit and the global enable bit are 1.
- R7: Among offered requests the winner follows the fixed order pin 0, timer 0, pin 1, timer 1, serial. `vec_addr` is 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 respectively.
- R8: `vec_ack` while `vec_valid` is 1 sets `in_service` at the next edge. While `in_service` is 1, `vec_valid` stays 0. `reti` clears `in_service`. `vec_ack` while `vec_valid` is 0 has no effect.
- R9: An accepted acknowledge clears the flag of the vectored source if that source is a timer or an edge-mode pin, and leaves every other flag unchanged.
- R10: Register writes take effect at the next edge. When a hardware set and a software write hit the same flag in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | External request pins, active low |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| rx_done | input | 1 | Serial byte received pulse |
| tx_done | input | 1 | Serial byte sent pulse |
| ctl_we | input | 1 | Write strobe, control image |
| ctl_wdata | input | 8 | Write data, control image |
| en_we | input | 1 | Write strobe, enable image |
| en_wdata | input | 8 | Write data, enable image |
| ser_we | input | 1 | Write strobe, serial flags |
| ser_wdata | input | 2 | Write data, serial flags |
| vec_ack | input | 1 | CPU takes the offered vector |
| reti | input | 1 | CPU leaves the service routine |
| ctl_q | output | 8 | Control image (modes and flags) |
| en_q | output | 8 | Enable image |
| ser_q | output | 2 | Serial flags (bit 0 receive, bit 1 transmit) |
| vec_valid | output | 1 | A vector is offered |
| vec_addr | output | 16 | Service address of the offered vector |
| in_service | output | 1 | A service routine is in progress |

## Verification
The assertions assume that the core raises `vec_ack` only as a one-cycle pulse in response to the offered vector. They also assume that `reti` is never pulsed in the same cycle as an acknowledge. The serial-keep check assumes that no serial register write lands in the acknowledge cycle. The timer-clear check assumes that no control write and no new overflow pulse arrives alongside the acknowledge. The bench drives every pulse for exactly one cycle and separates acknowledges, returns and writes into distinct cycles. In the priority sweep it holds the pins high with both pins in edge mode, so only the written flags can raise requests.

// File: rtl/irq5_pkg.sv
package irq5_pkg;
   localparam int unsigned SRC_N = 5;
   localparam int unsigned IDX_W = $clog2(SRC_N);

   // urgency order: lower value wins
   typedef enum logic [IDX_W-1:0] {
      SRC_PIN0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_PIN1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4
   } irq_src_e;

   // control image bit positions
   localparam int unsigned CB_MODE0 = 0;
   localparam int unsigned CB_FLAG0 = 1;
   localparam int unsigned CB_MODE1 = 2;
   localparam int unsigned CB_FLAG1 = 3;
   localparam int unsigned CB_TMR0  = 5;
   localparam int unsigned CB_TMR1  = 7;
   localparam int unsigned EB_ALL   = 7;
endpackage

// File: rtl/irq5_pin_sampler.sv
module irq5_pin_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall,
   output logic low
);
   logic now_q, old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q <= 1'b1;
         old_q <= 1'b1;
      end else begin
         now_q <= pin_n;
         old_q <= now_q;
      end
   end

   assign fall = old_q & ~now_q;
   assign low  = ~now_q;
endmodule

// File: rtl/irq5_pick.sv
module irq5_pick #(
   parameter int unsigned N   = 5,
   parameter int unsigned I_W = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req,
   output logic           any,
   output logic [I_W-1:0] idx
);
   initial begin
      if (N < 2) $error("irq5_pick: N must be at least 2");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            any = 1'b1;
            idx = I_W'(k);
         end
      end
   end

   AST_PICK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[idx]); // R7
   AST_NONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> !any); // R6
endmodule

// File: rtl/irq5_ctrl.sv
module irq5_ctrl
   import irq5_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8,
   parameter int unsigned PIN_N    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_N-1:0]  ext_pin_n,
   input  logic              t0_ovf,
   input  logic              t1_ovf,
   input  logic              rx_done,
   input  logic              tx_done,
   input  logic              ctl_we,
   input  logic [7:0]        ctl_wdata,
   input  logic              en_we,
   input  logic [7:0]        en_wdata,
   input  logic              ser_we,
   input  logic [1:0]        ser_wdata,
   input  logic              vec_ack,
   input  logic              reti,
   output logic [7:0]        ctl_q,
   output logic [7:0]        en_q,
   output logic [1:0]        ser_q,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              in_service
);
   localparam int unsigned TOP_VEC = VEC_BASE + VEC_STEP * (SRC_N - 1);
   localparam logic [7:0]  EN_MASK = 8'h80 | 8'((1 << SRC_N) - 1);

   if (PIN_N != 2) begin : g_bad_pins
      $error("irq5_ctrl: exactly two external pins are supported");
   end
   if (TOP_VEC >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq5_ctrl: ADDR_W too narrow for the vector table");
   end

   logic [PIN_N-1:0] pin_fall, pin_low;
   logic [7:0]       ctl_d, ctl_base;
   logic [1:0]       ser_d;
   logic [SRC_N-1:0] req_raw, req_on, clr_hit;
   logic             pick_any, take;
   logic [IDX_W-1:0] pick_idx;

   for (genvar p = 0; p < PIN_N; p++) begin : g_pin
      irq5_pin_sampler u_smp (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_n (ext_pin_n[p]),
         .fall  (pin_fall[p]),
         .low   (pin_low[p])
      );
   end

   assign take = vec_ack & vec_valid;

   always_comb begin
      clr_hit = '0;
      if (take) clr_hit[pick_idx] = 1'b1;
   end

   // control image next state
   always_comb begin
      ctl_base = ctl_we ? ctl_wdata : ctl_q;
      ctl_d    = ctl_base;
      for (int p = 0; p < PIN_N; p++) begin
         if (ctl_q[2*p]) begin
            // edge mode: latched, cleared on vectoring, new edge wins
            ctl_d[2*p+1] = (ctl_base[2*p+1] & ~clr_hit[2*p]) | pin_fall[p];
         end else begin
            ctl_d[2*p+1] = pin_low[p];
         end
      end
      ctl_d[CB_TMR0] = (ctl_base[CB_TMR0] & ~clr_hit[SRC_TMR0]) | t0_ovf;
      ctl_d[CB_TMR1] = (ctl_base[CB_TMR1] & ~clr_hit[SRC_TMR1]) | t1_ovf;
   end

   // serial flags: only software clears them
   assign ser_d = (ser_we ? ser_wdata : ser_q) | {tx_done, rx_done};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         en_q       <= '0;
         ser_q      <= '0;
         in_service <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         ser_q <= ser_d;
         if (en_we) en_q <= en_wdata & EN_MASK;
         if (take)      in_service <= 1'b1;
         else if (reti) in_service <= 1'b0;
      end
   end

   assign req_raw[SRC_PIN0] = ctl_q[CB_FLAG0];
   assign req_raw[SRC_TMR0] = ctl_q[CB_TMR0];
   assign req_raw[SRC_PIN1] = ctl_q[CB_FLAG1];
   assign req_raw[SRC_TMR1] = ctl_q[CB_TMR1];
   assign req_raw[SRC_SER]  = |ser_q;
   assign req_on = req_raw & en_q[SRC_N-1:0] & {SRC_N{en_q[EB_ALL]}};

   irq5_pick #(.N(SRC_N), .I_W(IDX_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_on),
      .any   (pick_any),
      .idx   (pick_idx)
   );

   assign vec_valid = pick_any & ~in_service;
   assign vec_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(pick_idx);

   AST_SVC_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      in_service |-> !vec_valid); // R8
   AST_ACK_ENTERS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && vec_valid) |=> in_service); // R8
   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> en_q[EB_ALL]); // R6
   AST_SER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && vec_valid && pick_idx == SRC_SER && !ser_we)
      |=> (($past(ser_q) & ~ser_q) == 2'b00)); // R5
   AST_TMR0_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && vec_valid && pick_idx == SRC_TMR0 && !ctl_we && !t0_ovf)
      |=> !ctl_q[CB_TMR0]); // R9
endmodule

// File: tb/irq5_ctrl_tb.sv
module irq5_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_pin_n = 2'b11;
   logic       t0_ovf = 0, t1_ovf = 0, rx_done = 0, tx_done = 0;
   logic       ctl_we = 0, en_we = 0, ser_we = 0, vec_ack = 0, reti = 0;
   logic [7:0] ctl_wdata = 0, en_wdata = 0;
   logic [1:0] ser_wdata = 0;
   logic [7:0] ctl_q, en_q;
   logic [1:0] ser_q;
   logic       vec_valid, in_service;
   logic [15:0] vec_addr;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk; // 125 MHz

   irq5_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n),
      .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .rx_done(rx_done), .tx_done(tx_done),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .en_we(en_we), .en_wdata(en_wdata),
      .ser_we(ser_we), .ser_wdata(ser_wdata), .vec_ack(vec_ack), .reti(reti),
      .ctl_q(ctl_q), .en_q(en_q), .ser_q(ser_q), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .in_service(in_service)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] c, input logic [7:0] e, input logic [1:0] s);
      ctl_we = 1; ctl_wdata = c; en_we = 1; en_wdata = e; ser_we = 1; ser_wdata = s;
      cyc();
      ctl_we = 0; en_we = 0; ser_we = 0;
   endtask

   task automatic pulse_ack();
      vec_ack = 1; cyc(); vec_ack = 0;
   endtask

   task automatic pulse_reti();
      reti = 1; cyc(); reti = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      // R1 reset state
      chk("R1 ctl", ctl_q, 0); chk("R1 en", en_q, 0); chk("R1 ser", ser_q, 0);
      chk("R1 valid", vec_valid, 0); chk("R1 svc", in_service, 0);

      // R6 R7 sweep: every pending pattern against every enable pattern
      for (int p = 0; p < 32; p++) begin
         for (int e = 0; e < 33; e++) begin
            logic [4:0] m;
            logic       g;
            int         lo;
            g = (e < 32);
            m = 5'(p) & (g ? 5'(e) : 5'h1F);
            wr({p[3], 1'b0, p[1], 1'b0, p[2], 1'b1, p[0], 1'b1},
               {1'b1 & g, 2'b00, (g ? 5'(e) : 5'h1F)}, {1'b0, p[4]});
            lo = 0;
            for (int k = 4; k >= 0; k--) if (m[k] && g) lo = k;
            chk("R6 valid", vec_valid, (g && m != 0));
            if (g && m != 0) chk("R7 addr", vec_addr, 3 + 8 * lo);
         end
      end
      wr(8'h05, 8'h00, 2'b00);
      chk("R10 write clears", ctl_q, 8'h05);

      // R2 edge mode on pin 0
      wr(8'h05, 8'h81, 2'b00);
      ext_pin_n[0] = 0;
      cyc(); chk("R2 not yet", ctl_q[1], 0);
      cyc(); chk("R2 flag set", ctl_q[1], 1);
      chk("R7 pin0 vec", vec_addr, 16'h0003); chk("R6 pin0 valid", vec_valid, 1);
      pulse_ack();
      chk("R8 svc", in_service, 1); chk("R8 hold", vec_valid, 0);
      chk("R9 edge clear", ctl_q[1], 0);
      pulse_reti();
      chk("R8 reti", in_service, 0);
      repeat (4) cyc();
      chk("R2 no retrigger", ctl_q[1], 0); chk("R2 idle", vec_valid, 0);
      ext_pin_n[0] = 1;
      cyc();

      // R3 level mode on pin 1
      wr(8'h01, 8'h84, 2'b00);
      ext_pin_n[1] = 0;
      cyc(); chk("R3 lag", ctl_q[3], 0);
      cyc(); chk("R3 low", ctl_q[3], 1); chk("R7 pin1 vec", vec_addr, 16'h0013);
      pulse_ack();
      chk("R9 level kept", ctl_q[3], 1); chk("R8 svc1", in_service, 1);
      ctl_we = 1; ctl_wdata = 8'h01; cyc(); ctl_we = 0;
      chk("R3 write ignored", ctl_q[3], 1);
      pulse_reti();
      ext_pin_n[1] = 1;
      cyc(); cyc();
      chk("R3 high", ctl_q[3], 0); chk("R3 idle", vec_valid, 0);

      // R8 ack with nothing offered
      pulse_ack();
      chk("R8 stray ack", in_service, 0);

      // R4 timers, R9 timer clear
      wr(8'h05, 8'h8A, 2'b00);
      t0_ovf = 1; cyc(); t0_ovf = 0;
      chk("R4 t0", ctl_q, 8'h25); chk("R7 t0 vec", vec_addr, 16'h000B);
      t1_ovf = 1; cyc(); t1_ovf = 0;
      chk("R4 t1", ctl_q, 8'hA5);
      pulse_ack();
      chk("R9 t0 cleared only", ctl_q, 8'h85);
      pulse_reti();
      chk("R7 t1 vec", vec_addr, 16'h001B);
      pulse_ack();
      chk("R9 t1 cleared", ctl_q, 8'h05);
      pulse_reti();

      // R10 set beats write
      ctl_we = 1; ctl_wdata = 8'h05; t0_ovf = 1; cyc(); ctl_we = 0; t0_ovf = 0;
      chk("R10 set wins", ctl_q, 8'h25);
      wr(8'h05, 8'h90, 2'b00);

      // R5 serial
      rx_done = 1; cyc(); rx_done = 0;
      chk("R5 rx", ser_q, 2'b01); chk("R7 ser vec", vec_addr, 16'h0023);
      tx_done = 1; cyc(); tx_done = 0;
      chk("R5 tx", ser_q, 2'b11);
      pulse_ack();
      chk("R5 kept", ser_q, 2'b11); chk("R8 svc ser", in_service, 1);
      pulse_reti();
      chk("R5 still pending", vec_valid, 1);
      ser_we = 1; ser_wdata = 2'b00; cyc(); ser_we = 0;
      chk("R5 sw clear", vec_valid, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule